// File: doc/BRIEF.md
# Triggered One-Shot Sample Capture Buffer

This block records a burst of byte samples from an external sample input into a 128-entry buffer at a rate set by software. Software first writes a 16-bit sample period, then arms the unit by writing a trigger bit. The unit takes samples at that rate until the buffer is full, then stops on its own. A capture is therefore never partly overwritten by a later one. A status bit tells software when the buffer is complete.

Software reads the captured bytes through a single data address. Each read returns the byte at a read pointer and then advances that pointer, which wraps from the last entry back to the first. A trigger clears both the write pointer and the read pointer, so a readout always starts at the oldest sample.

The controller is a three-state machine:
- IDLE is the state after reset.
- RUN is capture in progress.
- FULL means the buffer holds one complete capture.

Its transitions are:
- IDLE to RUN on a trigger.
- FULL to RUN on a trigger.
- RUN to RUN on a trigger, which restarts the capture.
- RUN to FULL when the last entry is stored.

Top module: `scope_capture`

## Requirements
- R1: After reset the unit is in IDLE, `capture_busy` is 0 and the status word reads 0.
- R2: The bus has two addresses. A write to address 0 loads the 16-bit period from `bus_wdata[15:0]`. Address 1 is the control address, and its read word carries the busy flag in bit 0 with all other bits 0. Address 1 can be read at any time without side effects.
- R3: A write to address 1 with `bus_wdata[0]`=1 starts a capture in the next cycle. It sets busy, resets the write pointer and read pointer to entry 0, and loads the rate counter with the period.
- R4: During a capture the rate counter counts down by one per clock. When it is 0, `sample_in` is stored at the write pointer and the counter reloads from the period. Sample j (counting from 0) is therefore the input seen at the (j+1)*(P+1)-th rising edge after the trigger edge.
- R5: A period of 0 stores one sample on every clock.
- R6: When entry 127 has been stored, the unit enters FULL and busy drops. No further samples are written until the next trigger.
- R7: A read strobe at address 0 returns the byte at the read pointer in bits 7:0, with the upper bits 0. After the read the pointer advances, wrapping from entry 127 to entry 0. The data word is driven combinationally from the current pointer.
- R8: A trigger during RUN restarts the capture from entry 0 with the current period.
- R9: A write to address 1 with `bus_wdata[0]`=0 has no effect: busy and the read pointer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_rd | input | 1 | Read strobe (with bus_sel); pops the buffer at address 0 |
| bus_addr | input | 1 | 0 = data/period, 1 = control/status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| sample_in | input | 8 | Sample source |
| capture_busy | output | 1 | High while a capture is in progress |

## Verification
The assertions assume the bus strobes are held for one cycle per access, with read and write strobes never asserted together. They also assume `bus_addr` and `bus_wdata` are stable across the sampling edge. The bench meets both conditions by driving every access on the falling edge and releasing it one cycle later. `sample_in` also changes only on falling edges, stepping by one each cycle. This lets every stored byte be predicted from the value present at the trigger edge. Period writes happen only while idle or directly before a restart trigger, so each capture runs at a single period.

// File: rtl/scope_pkg.sv
`timescale 1ns/1ps
package scope_pkg;
    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_RUN  = 2'd1,
        SC_FULL = 2'd2
    } cap_state_e;

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;
endpackage

// File: rtl/scope_rate_div.sv
`timescale 1ns/1ps
module scope_rate_div #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= period;
        end else if (en) begin
            if (cnt_q == '0) cnt_q <= period;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = en && !load && (cnt_q == '0);

    // R4: after a sample tick the counter holds the period in force at that tick
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == $past(period)));

    // R4: otherwise it steps down by exactly one
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5: with a zero period the counter stays at zero, so every running cycle ticks
    p_zero_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && period == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/scope_cap_fsm.sv
`timescale 1ns/1ps
module scope_cap_fsm
    import scope_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             tick,
    output logic             busy,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    cap_state_e state_q, state_d;
    logic       at_last;

    assign at_last = (wr_ptr == LAST);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SC_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE: if (trig) state_d = SC_RUN;
            SC_RUN: begin
                if (trig)                  state_d = SC_RUN;
                else if (tick && at_last)  state_d = SC_FULL;
            end
            SC_FULL: if (trig) state_d = SC_RUN;
            default: state_d = SC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy  = 1'b0;
        wr_en = 1'b0;
        unique case (state_q)
            SC_RUN: begin
                busy  = 1'b1;
                wr_en = tick && !trig;
            end
            SC_IDLE, SC_FULL: begin
                busy  = 1'b0;
                wr_en = 1'b0;
            end
            default: begin
                busy  = 1'b0;
                wr_en = 1'b0;
            end
        endcase
    end

    // write pointer
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_ptr <= '0;
        else if (trig)  wr_ptr <= '0;
        else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
    end

    // R3 / R8: a trigger always lands in RUN at entry 0
    p_trig_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (busy && wr_ptr == '0));

    // R6: storing the last entry ends the capture
    p_stop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at_last) |=> !busy);

    // R6: once idle or full, the pointer holds until a trigger
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !trig) |=> $stable(wr_ptr));
endmodule

// File: rtl/scope_sample_store.sv
`timescale 1ns/1ps
module scope_sample_store #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clr,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  rd_ptr_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rd_ptr_q <= '0;
        else if (rd_clr) rd_ptr_q <= '0;
        else if (rd_en)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end

    assign rd_data = mem_q[rd_ptr_q];

    // R7: the read pointer wraps from the last entry to the first
    p_rd_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_clr && rd_ptr_q == PTR_W'(DEPTH - 1)) |=> (rd_ptr_q == '0));

    // R3: a trigger returns the readout to the oldest entry
    p_rd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> (rd_ptr_q == '0));

    // R9: without a read or a trigger the pointer does not move
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !rd_clr) |=> $stable(rd_ptr_q));
endmodule

// File: rtl/scope_capture.sv
`timescale 1ns/1ps
module scope_capture
    import scope_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int SMP_W = 8,
    parameter int PER_W = 16,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [SMP_W-1:0] sample_in,
    output logic             capture_busy
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [PER_W-1:0] period_q;
    logic             wr_strobe, trig, rd_pop, tick, wr_en;
    logic [PTR_W-1:0] wr_ptr;
    logic [SMP_W-1:0] rd_byte;

    assign wr_strobe = bus_sel && bus_wr;
    assign trig      = wr_strobe && (bus_addr == ADDR_CTRL) && bus_wdata[0];
    assign rd_pop    = bus_sel && bus_rd && (bus_addr == ADDR_DATA);

    always_ff @(posedge clk) begin
        if (!rst_n)
            period_q <= '0;
        else if (wr_strobe && bus_addr == ADDR_DATA)
            period_q <= bus_wdata[PER_W-1:0];
    end

    scope_rate_div #(.PER_W(PER_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (trig),
        .en     (capture_busy),
        .period (period_q),
        .tick   (tick)
    );

    scope_cap_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig),
        .tick   (tick),
        .busy   (capture_busy),
        .wr_en  (wr_en),
        .wr_ptr (wr_ptr)
    );

    scope_sample_store #(.DEPTH(DEPTH), .DATA_W(SMP_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (sample_in),
        .rd_clr  (trig),
        .rd_en   (rd_pop),
        .rd_data (rd_byte)
    );

    always_comb begin
        if (bus_addr == ADDR_CTRL) bus_rdata = BUS_W'(capture_busy);
        else                       bus_rdata = BUS_W'(rd_byte);
    end

    // R9: a control write with bit 0 clear does not start a capture
    p_ignore_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && bus_addr == ADDR_CTRL && !bus_wdata[0] && !capture_busy)
        |=> !capture_busy);

    // R2: the period register changes only on a write to the data address
    p_period_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_strobe && bus_addr == ADDR_DATA) |=> $stable(period_q));
endmodule

// File: tb/tb_scope_capture.sv
`timescale 1ns/1ps
module tb_scope_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  smp = '0;
    logic        capture_busy;

    int n_vec  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    always @(negedge clk) smp <= smp + 8'd1;

    scope_capture dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sample_in(smp), .capture_busy(capture_busy)
    );

    // stimulus: period, expected capture length in clocks
    localparam int NV = 5;
    localparam logic [15:0] V_PER [NV] = '{16'd0, 16'd1, 16'd3, 16'd7, 16'd2};
    localparam int          V_LEN [NV] = '{128, 256, 512, 1024, 384};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // trigger and record the sample value present at the trigger edge
    task automatic trigger(output logic [7:0] base);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 16'h0001;
        @(posedge clk);
        base = smp;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic pop(output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 1'b0;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic status(output logic [15:0] d);
        bus_addr = 1'b1;
        #1 d = bus_rdata;
    endtask

    function automatic logic [7:0] expect_smp(logic [7:0] base, int j, int per);
        return 8'(int'(base) + (j + 1) * (per + 1));
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0]  base;
        logic [15:0] d;
        logic [7:0]  last_b;
        int          last_p;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(capture_busy == 1'b0, "R1 busy", capture_busy, 0);
        status(d);
        check(d == 16'h0000, "R1 status", d, 0);

        last_b = '0; last_p = 0;
        for (int v = 0; v < NV; v++) begin
            bus_write(1'b0, V_PER[v]);                      // R2 period
            trigger(base);
            check(capture_busy == 1'b1, "R3 busy after trigger", capture_busy, 1);
            status(d);
            check(d == 16'h0001, "R2 status word", d, 1);
            repeat (V_LEN[v] - 1) @(negedge clk);
            check(capture_busy == 1'b1, "R4 busy before last sample", capture_busy, 1);
            @(negedge clk);
            check(capture_busy == 1'b0, "R6 busy after full", capture_busy, 0);
            repeat (40) @(negedge clk);                     // R6 no more writes
            for (int j = 0; j < 128; j++) begin
                pop(d);
                check(d == {8'h00, expect_smp(base, j, int'(V_PER[v]))},
                      (V_PER[v] == 0) ? "R5 sample" : "R4 sample", d,
                      {8'h00, expect_smp(base, j, int'(V_PER[v]))});
            end
            for (int j = 0; j < 2; j++) begin
                pop(d);
                check(d == {8'h00, expect_smp(base, j, int'(V_PER[v]))},
                      "R7 wrap", d, {8'h00, expect_smp(base, j, int'(V_PER[v]))});
            end
            last_b = base; last_p = int'(V_PER[v]);
        end

        // R9: control write with bit 0 clear; read pointer stays at entry 2
        bus_write(1'b1, 16'h0000);
        repeat (10) @(negedge clk);
        check(capture_busy == 1'b0, "R9 busy", capture_busy, 0);
        pop(d);
        check(d == {8'h00, expect_smp(last_b, 2, last_p)}, "R9 pointer", d,
              {8'h00, expect_smp(last_b, 2, last_p)});

        // R8: restart a running capture with a new period
        bus_write(1'b0, 16'd5);
        trigger(base);
        repeat (30) @(negedge clk);
        pop(d); pop(d);
        bus_write(1'b0, 16'd1);
        trigger(base);
        check(capture_busy == 1'b1, "R8 busy after restart", capture_busy, 1);
        repeat (255) @(negedge clk);
        check(capture_busy == 1'b1, "R8 busy before end", capture_busy, 1);
        @(negedge clk);
        check(capture_busy == 1'b0, "R8 busy after end", capture_busy, 0);
        for (int j = 0; j < 128; j++) begin
            pop(d);
            check(d == {8'h00, expect_smp(base, j, 1)}, "R8 restarted sample", d,
                  {8'h00, expect_smp(base, j, 1)});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule